// File: doc/BRIEF.md
# Status Register Write Legalizer

This block holds the machine-level processor status register and makes sure it only ever contains a legal value. Writes arrive in one of two ways. A machine-mode write carries the full register. A supervisor-alias write can only reach the fields of the reduced supervisor view. In both cases the candidate value passes through one legalization stage before it is stored. That stage drops unimplemented bits, forces some fields to fixed values, keeps the width-select fields unchanged and recomputes the dirty-summary bit.

Three configuration inputs describe the surrounding core:
- whether user mode exists,
- whether the user-level interrupt extension exists,
- whether floating point lives in the integer register file.

The block drives the full machine read value and the masked supervisor read value. It also drives the effective privilege that loads and stores use when privilege modification is turned on.

Top module: `status_reg_legalizer`

## Requirements
- R1: In the machine read value, only these bits can be 1: bits 22..7, 5..3 and 1..0, the width fields 35..32 and the top summary bit 63. Bits 6 and 2, the endianness bits 37..36 and all other bits always read zero.
- R2: The extension-context field (bits 16..15) always reads 00, whatever value is written.
- R3: When the float-in-integer option is set during a write, the float state field (bits 14..13) is stored as 00. Otherwise that field takes the written value.
- R4: Bit 63 reads 1 exactly when at least one of the float field (14..13), the extension-context field (16..15) or the vector field (10..9) equals 11.
- R5: The two width-select fields (bits 33..32 and 35..34) each reset to 2'b10. No write ever changes them.
- R6: When a write happens without the user-interrupt extension, bits 4 and 0 are stored as 0. When a write happens without user mode, the privilege-modify bit 17 is stored as 0.
- R7: The supervisor read value equals the machine read value masked to these bits: 63, 33..32, 19, 18, 16..15, 14..13, 10..9, 8, 5, 4, 1 and 0. All other bits of the supervisor read value are zero.
- R8: A supervisor-alias write replaces only bits 19, 18, 16..15, 14..13, 10..9, 8, 5, 4, 1 and 0. Every other stored bit keeps its value, and the merged result then goes through the same legalization as a machine write, so bit 63 is recomputed.
- R9: For a non-fetch access with bit 17 set, the effective privilege output equals bits 12..11. Otherwise it equals the current privilege input. The encoding is 00 user, 01 supervisor, 11 machine.
- R10: After reset, the machine read value is zero except for bits 35..32, which read 4'b1010.
- R11: A write takes effect on the clock edge at which its strobe is high. If both strobes are high together, only the machine write is applied. With no strobe high, the stored value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_user_mode | input | 1 | User mode is implemented |
| cfg_user_intr | input | 1 | User-level interrupt extension is implemented |
| cfg_fp_in_int | input | 1 | Floating point uses the integer register file |
| m_wr_en | input | 1 | Machine-mode write strobe |
| s_wr_en | input | 1 | Supervisor-alias write strobe |
| wr_data | input | XLEN | Written value, shared by both strobes |
| cur_priv | input | 2 | Current privilege level |
| access_is_fetch | input | 1 | The access being qualified is an instruction fetch |
| m_rdata | output | XLEN | Machine read value |
| s_rdata | output | XLEN | Supervisor read value |
| eff_priv | output | 2 | Effective privilege for the access |

## Verification
The assertions check these behaviours on every cycle:
- the fixed-zero bits and the extension-context field (R1, R2),
- the consistency of the summary bit (R4),
- the stability of the width fields (R5),
- the confinement of the supervisor view (R7),
- the hold on idle cycles (R11),
- the protection of machine-only fields against supervisor writes (R8).

Some behaviours depend on the exact stored value after a particular sequence of writes, so only the bench's scenarios can show them:
- machine-over-supervisor priority when both strobes are high,
- the merge-then-legalize result of a supervisor write,
- the effective-privilege choice, including the fetch exemption,
- the reset value.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   // Field positions; these are architectural and decoded by neighbours.
   localparam int unsigned POS_UIE    = 0;
   localparam int unsigned POS_SIE    = 1;
   localparam int unsigned POS_MIE    = 3;
   localparam int unsigned POS_UPIE   = 4;
   localparam int unsigned POS_SPIE   = 5;
   localparam int unsigned POS_MPIE   = 7;
   localparam int unsigned POS_SPP    = 8;
   localparam int unsigned POS_VS_LO  = 9;
   localparam int unsigned POS_MPP_LO = 11;
   localparam int unsigned POS_FS_LO  = 13;
   localparam int unsigned POS_XS_LO  = 15;
   localparam int unsigned POS_MPRV   = 17;
   localparam int unsigned POS_SUM    = 18;
   localparam int unsigned POS_MXR    = 19;
   localparam int unsigned POS_UXL_LO = 32;
   localparam int unsigned POS_SXL_LO = 34;
   localparam int unsigned POS_BE_LO  = 36;

   localparam logic [1:0] CTX_OFF   = 2'b00;
   localparam logic [1:0] CTX_DIRTY = 2'b11;

   typedef enum logic [1:0] {
      PRIV_USER  = 2'b00,
      PRIV_SUPER = 2'b01,
      PRIV_MACH  = 2'b11
   } priv_e;

   // Bits a machine write may carry into storage.
   function automatic logic [63:0] mach_keep_mask();
      logic [63:0] m;
      m = '0;
      for (int i = 7; i <= 22; i++) m[i] = 1'b1;
      for (int i = 3; i <= 5; i++)  m[i] = 1'b1;
      m[1] = 1'b1;
      m[0] = 1'b1;
      return m;
   endfunction

   // Bits a supervisor-alias write may replace.
   function automatic logic [63:0] sup_write_mask();
      logic [63:0] m;
      m = '0;
      m[POS_MXR]  = 1'b1;
      m[POS_SUM]  = 1'b1;
      m[POS_XS_LO +: 2] = 2'b11;
      m[POS_FS_LO +: 2] = 2'b11;
      m[POS_VS_LO +: 2] = 2'b11;
      m[POS_SPP]  = 1'b1;
      m[POS_SPIE] = 1'b1;
      m[POS_UPIE] = 1'b1;
      m[POS_SIE]  = 1'b1;
      m[POS_UIE]  = 1'b1;
      return m;
   endfunction

   // Bits visible through the supervisor read view.
   function automatic logic [63:0] sup_view_mask(int unsigned xlen);
      logic [63:0] m;
      m = sup_write_mask();
      m[xlen-1] = 1'b1;
      if (xlen == 64) m[POS_UXL_LO +: 2] = 2'b11;
      return m;
   endfunction

   // All bits that may ever read as one.
   function automatic logic [63:0] live_mask(int unsigned xlen);
      logic [63:0] m;
      m = mach_keep_mask();
      m[xlen-1] = 1'b1;
      if (xlen == 64) begin
         m[POS_UXL_LO +: 2] = 2'b11;
         m[POS_SXL_LO +: 2] = 2'b11;
      end
      return m;
   endfunction

   function automatic logic [63:0] reset_value(int unsigned xlen, logic [1:0] xl);
      logic [63:0] m;
      m = '0;
      if (xlen == 64) begin
         m[POS_UXL_LO +: 2] = xl;
         m[POS_SXL_LO +: 2] = xl;
      end
      return m;
   endfunction

endpackage

// File: rtl/sreg_sup_merge.sv
module sreg_sup_merge
   import sreg_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] wr_val,
   output logic [XLEN-1:0] merged_val
);
   localparam logic [63:0]     WMASK_FULL = sup_write_mask();
   localparam logic [XLEN-1:0] WMASK      = WMASK_FULL[XLEN-1:0];

   // Lift: alias-visible writable fields come from the write, the rest stays.
   always_comb begin
      merged_val = (old_val & ~WMASK) | (wr_val & WMASK);
   end
endmodule

// File: rtl/sreg_legalize.sv
module sreg_legalize
   import sreg_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] cand_val,
   input  logic            cfg_user_mode,
   input  logic            cfg_user_intr,
   input  logic            cfg_fp_in_int,
   output logic [XLEN-1:0] legal_val
);
   localparam logic [63:0]     KEEP_FULL = mach_keep_mask();
   localparam logic [XLEN-1:0] KEEP      = KEEP_FULL[XLEN-1:0];

   logic [XLEN-1:0] base;
   logic            dirty;

   always_comb begin
      base = cand_val & KEEP;
      base[POS_XS_LO +: 2] = CTX_OFF;
      if (cfg_fp_in_int) base[POS_FS_LO +: 2] = CTX_OFF;
      if (!cfg_user_intr) begin
         base[POS_UPIE] = 1'b0;
         base[POS_UIE]  = 1'b0;
      end
      if (!cfg_user_mode) base[POS_MPRV] = 1'b0;
   end

   always_comb begin
      dirty = (base[POS_FS_LO +: 2] == CTX_DIRTY) ||
              (base[POS_XS_LO +: 2] == CTX_DIRTY) ||
              (base[POS_VS_LO +: 2] == CTX_DIRTY);
   end

   generate
      if (XLEN == 64) begin : g_wide
         always_comb begin
            legal_val = base;
            legal_val[POS_UXL_LO +: 2] = old_val[POS_UXL_LO +: 2];
            legal_val[POS_SXL_LO +: 2] = old_val[POS_SXL_LO +: 2];
            legal_val[POS_BE_LO  +: 2] = 2'b00;
            legal_val[XLEN-1]          = dirty;
         end
      end else begin : g_narrow
         always_comb begin
            legal_val = {dirty, base[XLEN-2:0]};
         end
      end
   endgenerate
endmodule

// File: rtl/sreg_eff_priv.sv
module sreg_eff_priv
   import sreg_pkg::*;
(
   input  logic       mprv,
   input  logic [1:0] mpp,
   input  logic [1:0] cur_priv,
   input  logic       is_fetch,
   output logic [1:0] eff_priv
);
   priv_e sel;

   always_comb begin
      if (mprv && !is_fetch) sel = priv_e'(mpp);
      else                   sel = priv_e'(cur_priv);
      eff_priv = sel;
   end
endmodule

// File: rtl/status_reg_legalizer.sv
module status_reg_legalizer
   import sreg_pkg::*;
#(
   parameter int unsigned XLEN     = 64,
   parameter logic [1:0]  RESET_XL = 2'b10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_user_mode,
   input  logic            cfg_user_intr,
   input  logic            cfg_fp_in_int,
   input  logic            m_wr_en,
   input  logic            s_wr_en,
   input  logic [XLEN-1:0] wr_data,
   input  logic [1:0]      cur_priv,
   input  logic            access_is_fetch,
   output logic [XLEN-1:0] m_rdata,
   output logic [XLEN-1:0] s_rdata,
   output logic [1:0]      eff_priv
);
   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("status_reg_legalizer: XLEN must be 32 or 64");
      end
   endgenerate

   localparam logic [63:0]     RST_FULL   = reset_value(XLEN, RESET_XL);
   localparam logic [XLEN-1:0] RST_VAL    = RST_FULL[XLEN-1:0];
   localparam logic [63:0]     SVIEW_FULL = sup_view_mask(XLEN);
   localparam logic [XLEN-1:0] SVIEW      = SVIEW_FULL[XLEN-1:0];
   localparam logic [63:0]     LIVE_FULL  = live_mask(XLEN);
   localparam logic [XLEN-1:0] LIVE       = LIVE_FULL[XLEN-1:0];

   logic [XLEN-1:0] stat_q;
   logic [XLEN-1:0] merged;
   logic [XLEN-1:0] cand;
   logic [XLEN-1:0] legal_next;
   logic            any_wr;

   sreg_sup_merge #(.XLEN(XLEN)) u_merge (
      .old_val    (stat_q),
      .wr_val     (wr_data),
      .merged_val (merged)
   );

   // Machine write wins over the alias.
   always_comb begin
      cand   = m_wr_en ? wr_data : merged;
      any_wr = m_wr_en | s_wr_en;
   end

   sreg_legalize #(.XLEN(XLEN)) u_legal (
      .old_val       (stat_q),
      .cand_val      (cand),
      .cfg_user_mode (cfg_user_mode),
      .cfg_user_intr (cfg_user_intr),
      .cfg_fp_in_int (cfg_fp_in_int),
      .legal_val     (legal_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat_q <= RST_VAL;
      else if (any_wr) stat_q <= legal_next;
   end

   sreg_eff_priv u_eff (
      .mprv     (stat_q[POS_MPRV]),
      .mpp      (stat_q[POS_MPP_LO +: 2]),
      .cur_priv (cur_priv),
      .is_fetch (access_is_fetch),
      .eff_priv (eff_priv)
   );

   always_comb begin
      m_rdata = stat_q;
      s_rdata = stat_q & SVIEW;
   end

   // ---------------- assertions ----------------
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (m_rdata & ~LIVE) == '0); // R1
   AST_XS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      m_rdata[POS_XS_LO +: 2] == CTX_OFF); // R2
   AST_FS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (any_wr && cfg_fp_in_int) |=> m_rdata[POS_FS_LO +: 2] == CTX_OFF); // R3
   AST_SD_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
      m_rdata[XLEN-1] == ((m_rdata[POS_FS_LO +: 2] == CTX_DIRTY) ||
                          (m_rdata[POS_XS_LO +: 2] == CTX_DIRTY) ||
                          (m_rdata[POS_VS_LO +: 2] == CTX_DIRTY))); // R4
   AST_UINT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (any_wr && !cfg_user_intr) |=> (!m_rdata[POS_UPIE] && !m_rdata[POS_UIE])); // R6
   AST_MPRV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (any_wr && !cfg_user_mode) |=> !m_rdata[POS_MPRV]); // R6
   AST_SVIEW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rdata & ~SVIEW) == '0); // R7
   AST_SWR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (s_wr_en && !m_wr_en) |=> $stable({m_rdata[22:20], m_rdata[POS_MPP_LO +: 2],
                                         m_rdata[POS_MPIE], m_rdata[POS_MIE]})); // R8
   AST_FETCH_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      access_is_fetch |-> eff_priv == cur_priv); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !any_wr |=> $stable(m_rdata)); // R11

   generate
      if (XLEN == 64) begin : g_xl_chk
         AST_XL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(m_rdata[POS_SXL_LO+1:POS_UXL_LO])); // R5
      end
   endgenerate
endmodule

// File: tb/status_reg_legalizer_tb.sv
`timescale 1ns/1ps
module status_reg_legalizer_tb;
   localparam logic [63:0] S_VIEW  = 64'h8000_0003_000D_E733; // R7 view bits
   localparam logic [63:0] RST_EXP = 64'h0000_000A_0000_0000; // R10

   typedef struct packed {
      logic [1:0]  kind;   // 1 machine, 2 supervisor, 3 both
      logic        um;
      logic        ui;
      logic        fpi;
      logic [63:0] data;
      logic [63:0] exp_m;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_000A_007E_7FBB}, // R1 R4
      '{2'd1, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_000A_007E_1FBB}, // R3
      '{2'd1, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_000A_007C_1FAA}, // R6
      '{2'd1, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_000A_0000_0000},
      '{2'd1, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_2000, 64'h0000_000A_0000_2000}, // R3 R4
      '{2'd1, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0600, 64'h8000_000A_0000_0600}, // R4
      '{2'd1, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0001_8000, 64'h0000_000A_0000_0000}, // R2
      '{2'd1, 1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'h0000_000A_0000_0000}, // R5 R1
      '{2'd1, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_1888, 64'h0000_000A_0000_1888},
      '{2'd2, 1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_000A_000C_7FBB}, // R8
      '{2'd2, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_000A_0000_1888}, // R8
      '{2'd3, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0002, 64'h0000_000A_0000_0002}, // R11
      '{2'd2, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0011, 64'h0000_000A_0000_0000}  // R6
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_user_mode = 1'b1;
   logic        cfg_user_intr = 1'b1;
   logic        cfg_fp_in_int = 1'b0;
   logic        m_wr_en = 1'b0;
   logic        s_wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic [1:0]  cur_priv = 2'b11;
   logic        access_is_fetch = 1'b0;
   logic [63:0] m_rdata;
   logic [63:0] s_rdata;
   logic [1:0]  eff_priv;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   status_reg_legalizer u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_user_mode   (cfg_user_mode),
      .cfg_user_intr   (cfg_user_intr),
      .cfg_fp_in_int   (cfg_fp_in_int),
      .m_wr_en         (m_wr_en),
      .s_wr_en         (s_wr_en),
      .wr_data         (wr_data),
      .cur_priv        (cur_priv),
      .access_is_fetch (access_is_fetch),
      .m_rdata         (m_rdata),
      .s_rdata         (s_rdata),
      .eff_priv        (eff_priv)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] kind, input logic um, input logic ui,
                           input logic fpi, input logic [63:0] data);
      @(negedge clk);
      cfg_user_mode = um;
      cfg_user_intr = ui;
      cfg_fp_in_int = fpi;
      wr_data = data;
      m_wr_en = kind[0];
      s_wr_en = kind[1];
      @(negedge clk);
      m_wr_en = 1'b0;
      s_wr_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset m_rdata", m_rdata, RST_EXP);
      chk("R7 reset s_rdata", s_rdata, RST_EXP & S_VIEW);
      chk("R9 reset eff_priv", {62'd0, eff_priv}, {62'd0, cur_priv});
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 after release", m_rdata, RST_EXP);

      for (int i = 0; i < NV; i++) begin
         do_write(VECS[i].kind, VECS[i].um, VECS[i].ui, VECS[i].fpi, VECS[i].data);
         chk($sformatf("R1-table vec %0d m_rdata", i), m_rdata, VECS[i].exp_m);
         chk($sformatf("R7 vec %0d s_rdata", i), s_rdata, VECS[i].exp_m & S_VIEW);
      end

      // R11: no strobe means no change
      do_write(2'd1, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0002_0800);
      chk("R11 write MPRV/MPP", m_rdata, 64'h0000_000A_0002_0800);
      @(negedge clk);
      wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
      repeat (3) @(negedge clk);
      chk("R11 idle hold", m_rdata, 64'h0000_000A_0002_0800);

      // R9 effective privilege
      cur_priv = 2'b11;
      access_is_fetch = 1'b0;
      #1;
      chk("R9 load uses MPP", {62'd0, eff_priv}, 64'd1);
      access_is_fetch = 1'b1;
      #1;
      chk("R9 fetch uses current", {62'd0, eff_priv}, 64'd3);
      do_write(2'd1, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0800);
      cur_priv = 2'b00;
      access_is_fetch = 1'b0;
      #1;
      chk("R9 MPRV clear uses current", {62'd0, eff_priv}, 64'd0);

      // R6 MPRV dropped without user mode
      do_write(2'd1, 1'b0, 1'b1, 1'b0, 64'h0000_0000_0002_0800);
      chk("R6 MPRV without user mode", m_rdata, 64'h0000_000A_0000_0800);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule